// File: doc/BRIEF.md
# Window Watchdog with Supervisor Reset

This block supervises an external processor. It drives an active-low reset line to that processor from four synchronous inputs: a supply-good flag, an enable, a sleep request and a service trigger. A free-running tick strobe sets the time base. Every period is a parameter counted in ticks.

When the supply becomes good, the block holds reset for a long period and then releases it. The processor must then send one rising edge on the trigger during a lead interval. If it does, the watchdog enters a repeating window cycle. Each cycle has a closed part, where a trigger is a fault, followed by an open part, where a trigger is the expected service.

A trigger in the closed part produces a short reset pulse. A missing trigger, either in the lead interval or by the end of the open part, produces a new long reset, which is again followed by a lead interval. Clearing the enable or raising the sleep request parks the watchdog with reset released. Losing the supply forces reset at once.

Top module: `wdog_window_supervisor`

## Requirements
- R1: While the synchronous reset `rst` is high, `mcu_rst_n` is driven low on the following clock.
- R2: One clock after a cycle in which `supply_ok` is low, `mcu_rst_n` is low. It stays low for as long as `supply_ok` stays low.
- R3: Once `supply_ok` is high, `mcu_rst_n` stays low for `T_RES` tick strobes and then goes high. It may only rise if `supply_ok` was high on the previous clock.
- R4: If no rising trigger edge is seen within `T_LEAD` ticks after reset releases, a new long reset of `T_RES` ticks follows.
- R5: A rising edge on `trig_in` acts three clocks after the edge in which it is first sampled, because of two synchronizer flops and the state register. During the lead interval, such an edge starts a closed section of `T1` ticks, and reset stays released.
- R6: A rising trigger edge during the closed section gives a short reset of `T_RESSHORT` ticks. When that pulse ends, a new closed section starts.
- R7: A rising trigger edge during the open section of `T2` ticks is a valid service. It starts a new closed section without any reset.
- R8: If the open section ends with no trigger, a long reset of `T_RES` ticks follows, and then a new lead interval.
- R9: While `wd_en` is low, the only resets are the supply-driven long reset and `rst`. Triggers and timeouts leave `mcu_rst_n` high.
- R10: While `sleep_req` is high, the watchdog is stopped and `mcu_rst_n` stays high once released. When sleep ends, a new lead interval starts.
- R11: Trigger edges that occur while reset is asserted are ignored. A trigger held high across the release of reset does not count as the first trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock time-base strobe; all periods count these |
| supply_ok | input | 1 | High while the supervised supply is above its good threshold |
| wd_en | input | 1 | Watchdog enable; low leaves only supply-driven resets |
| sleep_req | input | 1 | High stops the watchdog |
| trig_in | input | 1 | Asynchronous service trigger from the processor |
| mcu_rst_n | output | 1 | Registered active-low reset to the processor |

## Verification
The bench builds the block with `T_RES`=5, `T_RESSHORT`=2, `T_LEAD`=8, `T1`=4 and `T2`=4. It drives a tick on every third clock. With these values, every phase lasts only 6 to 24 clocks. As a result, early, valid and missing triggers, lead timeouts, sleep, disable and supply loss can all be reached in a few hundred cycles. Because the tick period is longer than one clock, the off-by-one limit of each period and the three-clock trigger latency can both be observed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    WS_OFF    = 3'd0,
    WS_LONG   = 3'd1,
    WS_LEAD   = 3'd2,
    WS_CLOSED = 3'd3,
    WS_OPEN   = 3'd4,
    WS_SHORT  = 3'd5,
    WS_IDLE   = 3'd6
  } wd_state_t;

  // States in which the processor reset line is held low
  function automatic logic holds_reset(input wd_state_t s);
    return (s == WS_OFF) || (s == WS_LONG) || (s == WS_SHORT);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdog_trig_sync.sv
module wdog_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // The last synchronized stage is compared with its delayed copy
  assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // The limit-th strobe since the phase started closes it
  assign expire = tick && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
  import wdog_pkg::*;
#(
  parameter int T_RES      = 20,
  parameter int T_RESSHORT = 4,
  parameter int T_LEAD     = 100,
  parameter int T1         = 30,
  parameter int T2         = 30,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok,
  input  logic             wd_en,
  input  logic             sleep_req,
  input  logic             trig_rise,
  input  logic             expire,
  output logic             tmr_clr,
  output logic [CNT_W-1:0] tmr_limit,
  output logic             rst_n_q
);
  localparam logic [CNT_W-1:0] L_RES   = CNT_W'(T_RES);
  localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(T_RESSHORT);
  localparam logic [CNT_W-1:0] L_LEAD  = CNT_W'(T_LEAD);
  localparam logic [CNT_W-1:0] L_T1    = CNT_W'(T1);
  localparam logic [CNT_W-1:0] L_T2    = CNT_W'(T2);

  wd_state_t st_q, st_d;
  logic      wd_on;

  assign wd_on = wd_en & ~sleep_req;

  always_comb begin
    st_d = st_q;
    if (!supply_ok) begin
      st_d = WS_OFF;
    end else begin
      unique case (st_q)
        WS_OFF:    st_d = WS_LONG;
        WS_LONG:   if (expire) st_d = wd_on ? WS_LEAD : WS_IDLE;
        WS_SHORT:  if (expire) st_d = wd_on ? WS_CLOSED : WS_IDLE;
        WS_IDLE:   if (wd_on)  st_d = WS_LEAD;
        WS_LEAD: begin
          if (!wd_on)         st_d = WS_IDLE;
          else if (trig_rise) st_d = WS_CLOSED;
          else if (expire)    st_d = WS_LONG;
        end
        WS_CLOSED: begin
          if (!wd_on)         st_d = WS_IDLE;
          else if (trig_rise) st_d = WS_SHORT;
          else if (expire)    st_d = WS_OPEN;
        end
        WS_OPEN: begin
          if (!wd_on)         st_d = WS_IDLE;
          else if (trig_rise) st_d = WS_CLOSED;
          else if (expire)    st_d = WS_LONG;
        end
        default:              st_d = WS_OFF;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      WS_LEAD:   tmr_limit = L_LEAD;
      WS_CLOSED: tmr_limit = L_T1;
      WS_OPEN:   tmr_limit = L_T2;
      WS_SHORT:  tmr_limit = L_SHORT;
      default:   tmr_limit = L_RES;
    endcase
  end

  assign tmr_clr = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= WS_OFF;
      rst_n_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rst_n_q <= ~holds_reset(st_d);
    end
  end

endmodule

// File: rtl/wdog_window_supervisor.sv
module wdog_window_supervisor
  import wdog_pkg::*;
#(
  parameter int T_RES       = 20,
  parameter int T_RESSHORT  = 4,
  parameter int T_LEAD      = 100,
  parameter int T1          = 30,
  parameter int T2          = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_en,
  input  logic sleep_req,
  input  logic trig_in,
  output logic mcu_rst_n
);
  localparam int MAX_T = max_of(max_of(T_RES, T_RESSHORT),
                                max_of(T_LEAD, max_of(T1, T2)));
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             trig_rise;
  logic             expire;
  logic             tmr_clr;
  logic [CNT_W-1:0] tmr_limit;

  wdog_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (trig_in),
    .rise     (trig_rise)
  );

  wdog_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .tick   (tick),
    .limit  (tmr_limit),
    .expire (expire)
  );

  wdog_fsm #(
    .T_RES      (T_RES),
    .T_RESSHORT (T_RESSHORT),
    .T_LEAD     (T_LEAD),
    .T1         (T1),
    .T2         (T2),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .wd_en     (wd_en),
    .sleep_req (sleep_req),
    .trig_rise (trig_rise),
    .expire    (expire),
    .tmr_clr   (tmr_clr),
    .tmr_limit (tmr_limit),
    .rst_n_q   (mcu_rst_n)
  );

endmodule

// File: rtl/wdog_sva.sv
module wdog_sva (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic wd_en,
  input logic sleep_req,
  input logic mcu_rst_n
);

  // R2: a supply drop forces reset on the next clock
  p_supply_low_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !mcu_rst_n);

  // R3: reset is only released after a good-supply cycle
  p_release_supply_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mcu_rst_n) |-> $past(supply_ok));

  // R9: disabled watchdog never pulls a released reset low
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (mcu_rst_n && !wd_en && supply_ok) |=> mcu_rst_n);

  // R10: sleeping watchdog never pulls a released reset low
  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (mcu_rst_n && sleep_req && supply_ok) |=> mcu_rst_n);

  // R1: the output is always a defined level once out of reset
  p_known_out_r1: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(mcu_rst_n));

endmodule

bind wdog_window_supervisor wdog_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .wd_en     (wd_en),
  .sleep_req (sleep_req),
  .mcu_rst_n (mcu_rst_n)
);

// File: tb/sim_wdog_window_supervisor.sv
`timescale 1ns/1ps
module sim_wdog_window_supervisor;
  localparam int T_RES = 5, T_RS = 2, T_LEAD = 8, T1 = 4, T2 = 4;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic supply_ok = 1'b0;
  logic wd_en = 1'b1;
  logic sleep_req = 1'b0;
  logic trig_in = 1'b0;
  logic mcu_rst_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_window_supervisor #(
    .T_RES(T_RES), .T_RESSHORT(T_RS), .T_LEAD(T_LEAD), .T1(T1), .T2(T2)
  ) u0 (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
    .wd_en(wd_en), .sleep_req(sleep_req), .trig_in(trig_in),
    .mcu_rst_n(mcu_rst_n)
  );

  // Tick strobe on every TICK_DIV-th clock
  initial begin
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      tick = (cyc % TICK_DIV) == 0;
    end
  end

  // Behavioural reference: phase 0 off,1 long,2 lead,3 closed,4 open,5 short,6 idle
  int  ph = 0;
  int  tcount = 0;
  bit  h1 = 0, h2 = 0, h3 = 0;
  bit  exp_n = 0;
  int  trq[$];

  always @(posedge clk) begin
    bit tr, on, ex;
    int nx, lim;
    if (rst) begin
      ph = 0; tcount = 0; h1 = 0; h2 = 0; h3 = 0; exp_n = 0;
      trq.delete();
    end else begin
      tr = h2 && !h3;
      trq.push_back(int'(tr));
      h3 = h2; h2 = h1; h1 = trig_in;
      case (ph)
        2: lim = T_LEAD;
        3: lim = T1;
        4: lim = T2;
        5: lim = T_RS;
        default: lim = T_RES;
      endcase
      ex = tick && (tcount == lim - 1);
      on = wd_en && !sleep_req;
      nx = ph;
      if (!supply_ok) nx = 0;
      else case (ph)
        0: nx = 1;
        1: if (ex) nx = on ? 2 : 6;
        5: if (ex) nx = on ? 3 : 6;
        6: if (on) nx = 2;
        2: if (!on) nx = 6; else if (tr) nx = 3; else if (ex) nx = 1;
        3: if (!on) nx = 6; else if (tr) nx = 5; else if (ex) nx = 4;
        4: if (!on) nx = 6; else if (tr) nx = 3; else if (ex) nx = 1;
        default: nx = 0;
      endcase
      if (nx != ph) tcount = 0;
      else if (tick) tcount = tcount + 1;
      ph = nx;
      exp_n = !(ph == 0 || ph == 1 || ph == 5);
    end
    started = 1;
  end

  function automatic string phase_tag(input int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  // Per-clock comparison with the reference, sampled mid-cycle
  always @(negedge clk) begin
    if (started && !done) begin
      n_chk = n_chk + 1;
      if (mcu_rst_n !== exp_n) begin
        n_fail = n_fail + 1;
        $display("FAIL %s: mcu_rst_n=%0b expected %0b at cycle %0d",
                 phase_tag(ph), mcu_rst_n, exp_n, cyc);
      end
    end
  end

  task automatic chk(input string tag, input logic expv);
    n_chk = n_chk + 1;
    if (mcu_rst_n !== expv) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: mcu_rst_n=%0b expected %0b at cycle %0d",
               tag, mcu_rst_n, expv, cyc);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_release(input string tag);
    int k = 0;
    while (mcu_rst_n !== 1'b1 && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(tag, 1'b1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    clocks(200000 - 10);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run hung, ran %0d cycles expected fewer", cyc);
    finish_run();
  end

  initial begin
    clocks(4);
    chk("R1", 1'b0);
    rst = 1'b0;
    clocks(5);
    chk("R2", 1'b0);

    // R3: power-up long reset then release
    supply_ok = 1'b1;
    clocks(3);
    chk("R3", 1'b0);
    wait_release("R3");

    // R4: no trigger in the lead interval gives a new long reset
    clocks(T_LEAD * TICK_DIV + 4);
    chk("R4", 1'b0);
    wait_release("R4");

    // R5: first trigger in lead starts the window cycle
    clocks(2);
    pulse_trig();
    clocks(6);
    chk("R5", 1'b1);

    // R6: trigger in the closed section gives a short pulse
    pulse_trig();
    clocks(1);
    chk("R6", 1'b0);
    wait_release("R6");

    // R7: trigger in the open section is a valid service
    clocks(15);
    pulse_trig();
    clocks(4);
    chk("R7", 1'b1);

    // R8: missing service at the end of the open section
    clocks(26);
    chk("R8", 1'b0);
    wait_release("R8");

    // R9: disabled watchdog ignores triggers and timeouts
    wd_en = 1'b0;
    clocks(3);
    pulse_trig();
    clocks(60);
    chk("R9", 1'b1);
    supply_ok = 1'b0;
    clocks(3);
    chk("R2", 1'b0);
    supply_ok = 1'b1;
    clocks(30);
    chk("R9", 1'b1);

    // R10: sleep freezes the watchdog
    wd_en = 1'b1;
    clocks(3);
    pulse_trig();
    sleep_req = 1'b1;
    clocks(60);
    chk("R10", 1'b1);
    sleep_req = 1'b0;
    clocks(2);
    pulse_trig();
    clocks(4);
    chk("R10", 1'b1);

    // R11: trigger raised during reset does not serve the lead interval
    supply_ok = 1'b0;
    clocks(2);
    supply_ok = 1'b1;
    clocks(2);
    trig_in = 1'b1;
    wait_release("R11");
    clocks(T_LEAD * TICK_DIV + 4);
    chk("R11", 1'b0);
    trig_in = 1'b0;
    wait_release("R11");
    clocks(5);

    finish_run();
  end

endmodule